// File: doc/BRIEF.md
# Dithered First-Order Sigma-Delta Modulator

This block turns a stream of signed PCM samples into a one-bit pulse-density stream. It uses a first-order error-feedback loop. A held sample is compared with an error accumulator, and the comparison gives the output bit. The accumulator then takes in a full-scale feedback of plus or minus 65536, loses the sample, and gains a small pseudo-random term. That term is the top bits of a 32-bit word that advances one CRC step per bit, with the held sample folded in as data.

Output bits are issued at a fixed pace, one every `TICKS_PER_BIT` clocks (35 by default). Each accepted sample stays in use for `BITS_PER_SAMPLE` bits (64 by default). The sample source sees a valid/ready pair. Ready is raised for exactly one clock, the clock whose rising edge closes the last bit of a group. A sample offered with valid in that clock is used from the next bit on. If no sample is offered, the previous one is used for another whole group.

Top module: `sdm_dither_mod`

## Requirements
- R1: While `rst_n` is low, `pdm_out` and `in_ready` are 0. The error accumulator, the dither word and the held sample all start at zero.
- R2: A bit update happens on every `TICKS_PER_BIT`-th rising clock edge after reset is released, the first one on edge number `TICKS_PER_BIT`. `pdm_out` changes on no other edge.
- R3: At each bit update, `pdm_out` becomes 1 when the held sample, read as signed and sign-extended, is greater than or equal to the signed error accumulator. Otherwise it becomes 0.
- R4: At each bit update, the accumulator becomes `err + F - x + (d' >> DITHER_SHIFT)` in 32-bit two's-complement arithmetic. Here F is +65536 when the new bit is 1 and -65536 when it is 0, x is the sign-extended held sample, and d' is the dither word after this bit's step. The accumulator stays within plus or minus (65536 + 2^(33-DITHER_SHIFT) + 2^15).
- R5: At each bit update, the dither word is XORed with the sign-extended held sample. It then goes through 32 rounds in which it shifts right by one, and a round whose shifted-out bit was 1 also XORs in 0xEB31D82E. The dither word does not change between updates.
- R6: `in_ready` is 1 only in the clock whose rising edge performs the last of the `BITS_PER_SAMPLE` updates of a group. A sample with `in_valid` high in that clock becomes the held sample and is used from the next update on, so each sample is accepted exactly once.
- R7: If `in_valid` is low in the ready clock, the held sample is kept and is used for the whole next group. Data offered outside the ready clock has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_data` |
| in_ready | output | 1 | One-clock acceptance window at the end of a group |
| in_data | input | IN_W | Signed PCM sample |
| pdm_out | output | 1 | Pulse-density output bit |

## Verification
A bit decision shows on `pdm_out` one register stage after the bit-update edge: the first appears right after edge `TICKS_PER_BIT` following reset release, and each later one comes exactly `TICKS_PER_BIT` edges after the one before. `in_ready` is decoded from the counters, so it is valid during the clock that ends a group. An accepted sample first affects the bit produced one full bit period later. The bench steps an arithmetic model of the loop in lockstep with the rising edges. It compares `pdm_out` and `in_ready` against that model at each falling edge, so every update is checked in the exact cycle it is due and the output is checked to hold in every other cycle.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   // Width of the pseudo-random dither word (one CRC-32 register).
   localparam int unsigned DITHER_W = 32;

   // Number of single-bit rounds applied per dither step.
   localparam int unsigned CRC_ROUNDS = 32;

   typedef logic [DITHER_W-1:0] dither_t;

   // One reflected CRC round: shift right, fold in the polynomial when
   // the bit leaving the register is set.
   function automatic dither_t crc_round(input dither_t st, input dither_t poly);
      dither_t sh;
      sh = st >> 1;
      return st[0] ? (sh ^ poly) : sh;
   endfunction

endpackage

// File: rtl/sdm_tick_gen.sv
module sdm_tick_gen #(
   parameter int unsigned TICKS = 35,
   parameter int unsigned BITS  = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_stb,
   output logic grp_end
);

   localparam int unsigned TW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam int unsigned BW = (BITS > 1) ? $clog2(BITS) : 1;
   localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);

   logic [TW-1:0] tick_q;
   logic [BW-1:0] bit_q;

   // A bit update fires in the last tick of each bit period.
   assign bit_stb = (tick_q == TICK_LAST);
   assign grp_end = bit_stb && (bit_q == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
      end else if (bit_stb) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
      end else if (bit_stb) begin
         if (bit_q == BIT_LAST) begin
            bit_q <= '0;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdm_dither_gen.sv
module sdm_dither_gen
   import sdm_pkg::*;
#(
   parameter int unsigned IN_W = 16,
   parameter logic [DITHER_W-1:0] POLY = 32'hEB31D82E
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step,
   input  logic signed [IN_W-1:0] sample,
   output dither_t                dither_q,
   output dither_t                dither_nxt
);

   dither_t seed;
   dither_t stage [CRC_ROUNDS+1];

   // The sample is sign-extended and mixed in before the rounds.
   assign seed     = DITHER_W'(sample);
   assign stage[0] = dither_q ^ seed;

   for (genvar r = 0; r < CRC_ROUNDS; r++) begin : g_round
      assign stage[r+1] = crc_round(stage[r], POLY);
   end

   assign dither_nxt = stage[CRC_ROUNDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dither_q <= '0;
      end else if (step) begin
         dither_q <= dither_nxt;
      end
   end

endmodule

// File: rtl/sdm_err_loop.sv
module sdm_err_loop
   import sdm_pkg::*;
#(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned FB_MAG = 65536,
   parameter int unsigned SHIFT  = 25
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic signed [IN_W-1:0]  sample,
   input  dither_t                 dither_nxt,
   output logic                    bit_q,
   output logic signed [ACC_W-1:0] err_q
);

   localparam logic signed [ACC_W-1:0] FB_POS = ACC_W'(FB_MAG);
   localparam logic signed [ACC_W-1:0] FB_NEG = -FB_POS;

   logic signed [ACC_W-1:0] x_ext;
   logic signed [ACC_W-1:0] d_term;
   logic signed [ACC_W-1:0] fb;
   logic signed [ACC_W-1:0] err_n;
   logic                    decide;

   assign x_ext  = ACC_W'(sample);
   assign d_term = ACC_W'(dither_nxt >> SHIFT);
   assign decide = (x_ext >= err_q);
   assign fb     = decide ? FB_POS : FB_NEG;
   assign err_n  = err_q + fb - x_ext + d_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         err_q <= '0;
      end else if (step) begin
         bit_q <= decide;
         err_q <= err_n;
      end
   end

endmodule

// File: rtl/sdm_dither_mod.sv
module sdm_dither_mod
   import sdm_pkg::*;
#(
   parameter int unsigned IN_W            = 16,
   parameter int unsigned ACC_W           = 32,
   parameter int unsigned TICKS_PER_BIT   = 35,
   parameter int unsigned BITS_PER_SAMPLE = 64,
   parameter int unsigned DITHER_SHIFT    = 25,
   parameter int unsigned FB_MAG          = 65536,
   parameter logic [31:0] POLY            = 32'hEB31D82E
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic signed [IN_W-1:0] in_data,
   output logic                   pdm_out
);

   // Elaboration-time parameter checks.
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be at least 2");
   end
   if (BITS_PER_SAMPLE < 2) begin : g_bad_bits
      $error("BITS_PER_SAMPLE must be at least 2");
   end
   if (IN_W < 2 || IN_W > 24) begin : g_bad_inw
      $error("IN_W must lie in 2..24");
   end
   if (ACC_W < 24 || ACC_W > 32) begin : g_bad_accw
      $error("ACC_W must lie in 24..32");
   end
   if (DITHER_SHIFT < 8 || DITHER_SHIFT > 31) begin : g_bad_shift
      $error("DITHER_SHIFT must lie in 8..31");
   end
   if (FB_MAG <= (1 << (IN_W - 1))) begin : g_bad_fb
      $error("FB_MAG must exceed the largest input magnitude");
   end

   logic                    bit_stb;
   logic                    grp_end;
   logic signed [IN_W-1:0]  held_q;
   dither_t                 dither_q;
   dither_t                 dither_nxt;
   logic signed [ACC_W-1:0] err_q;

   sdm_tick_gen #(
      .TICKS (TICKS_PER_BIT),
      .BITS  (BITS_PER_SAMPLE)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .grp_end (grp_end)
   );

   // The acceptance window is the single clock that closes a group.
   assign in_ready = grp_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (in_valid && grp_end) begin
         held_q <= in_data;
      end
   end

   sdm_dither_gen #(
      .IN_W (IN_W),
      .POLY (POLY)
   ) u_dith (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (bit_stb),
      .sample     (held_q),
      .dither_q   (dither_q),
      .dither_nxt (dither_nxt)
   );

   sdm_err_loop #(
      .IN_W   (IN_W),
      .ACC_W  (ACC_W),
      .FB_MAG (FB_MAG),
      .SHIFT  (DITHER_SHIFT)
   ) u_loop (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (bit_stb),
      .sample     (held_q),
      .dither_nxt (dither_nxt),
      .bit_q      (pdm_out),
      .err_q      (err_q)
   );

endmodule

// File: rtl/sdm_dither_chk.sv
module sdm_dither_chk #(
   parameter int unsigned IN_W         = 16,
   parameter int unsigned ACC_W        = 32,
   parameter int unsigned DITHER_SHIFT = 25,
   parameter int unsigned FB_MAG       = 65536
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic                    pdm_out,
   input logic                    bit_stb,
   input logic signed [IN_W-1:0]  held,
   input logic [31:0]             dither,
   input logic signed [ACC_W-1:0] err
);

   localparam longint LIM = longint'(FB_MAG)
                          + (longint'(1) << (33 - DITHER_SHIFT))
                          + (longint'(1) << (IN_W - 1));

   // R6: the acceptance window lasts exactly one clock.
   p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);

   // R6: the window only opens on a bit-update clock.
   p_ready_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_stb);

   // R2: the output holds between bit updates.
   p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(pdm_out));

   // R5: the dither word holds between bit updates.
   p_dither_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(dither));

   // R7: the held sample changes only through an accepted handshake.
   p_sample_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> $stable(held));

   // R4: the error accumulator stays bounded.
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(err) <= LIM) && (longint'(err) >= -LIM));

endmodule

bind sdm_dither_mod sdm_dither_chk #(
   .IN_W         (IN_W),
   .ACC_W        (ACC_W),
   .DITHER_SHIFT (DITHER_SHIFT),
   .FB_MAG       (FB_MAG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .pdm_out  (pdm_out),
   .bit_stb  (bit_stb),
   .held     (held_q),
   .dither   (dither_q),
   .err      (err_q)
);

// File: tb/sim_sdm_dither_mod.sv
`timescale 1ns/1ps
module sim_sdm_dither_mod;

   localparam int T  = 4;
   localparam int B  = 8;
   localparam int SH = 25;
   localparam logic [31:0] PL = 32'hEB31D82E;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic in_ready;
   logic pdm_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // Model state, stepped on each rising edge.
   int mtick = 0;
   int mbit = 0;
   logic signed [15:0] mcur = '0;
   logic signed [31:0] merr = '0;
   logic [31:0] md = '0;
   logic mout = 1'b0;

   always #2 clk = ~clk;

   sdm_dither_mod #(
      .TICKS_PER_BIT   (T),
      .BITS_PER_SAMPLE (B),
      .DITHER_SHIFT    (SH)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .pdm_out  (pdm_out)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic exp_ready();
      return (mtick == T-1) && (mbit == B-1);
   endfunction

   task automatic model_edge(input logic v, input logic signed [15:0] d);
      logic signed [31:0] x32;
      logic b;
      if (mtick == T-1) begin
         x32 = {{16{mcur[15]}}, mcur};
         b = (x32 >= merr);
         md = md ^ x32;
         for (int r = 0; r < 32; r++) begin
            md = md[0] ? ((md >> 1) ^ PL) : (md >> 1);
         end
         merr = merr + (b ? 32'sd65536 : -32'sd65536) - x32 + $signed(md >> SH);
         mout = b;
         if (mbit == B-1) begin
            if (v) mcur = d;
            mbit = 0;
         end else begin
            mbit++;
         end
         mtick = 0;
      end else begin
         mtick++;
      end
   endtask

   // One clock: check the outputs at the falling edge, drive inputs, step.
   task automatic cycle(input string otag, input logic v, input logic signed [15:0] d);
      @(negedge clk);
      check({otag, " R6 in_ready"}, in_ready, exp_ready());
      check({otag, " pdm_out"}, pdm_out, mout);
      in_valid = v;
      in_data = d;
      @(posedge clk);
      model_edge(v, d);
   endtask

   // mode 0: valid held with a steady value; 1: valid held with the data
   // changing each clock (only the ready clock matters, R6 R7);
   // 2: valid low for the whole group (R7, sample is kept).
   task automatic group(input int mode, input logic signed [15:0] val);
      string tg;
      tg = (mode == 2) ? "R7 R3 R4 R5 R2" : "R2 R3 R4 R5";
      for (int c = 0; c < T*B; c++) begin
         logic signed [15:0] dd;
         logic vv;
         vv = (mode != 2);
         dd = val;
         if (mode == 1 && !exp_ready()) dd = val ^ 16'(c * 16'h1357 + 16'h0badd);
         if (mode == 2) dd = 16'h7abc;
         cycle(tg, vv, dd);
      end
   endtask

   initial begin
      // R1: outputs quiet during reset.
      repeat (3) begin
         @(negedge clk);
         check("R1 pdm_out in reset", pdm_out, 1'b0);
         check("R1 in_ready in reset", in_ready, 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      model_edge(1'b0, '0);
      // First group runs on the zero sample: R1 R3 R4 give alternating bits.
      group(2, '0);
      group(0, 16'sd0);
      group(0, 16'sh7fff);
      group(0, -16'sd32768);
      group(0, -16'sd1);
      group(1, 16'sd1);
      group(2, 16'sd0);
      group(0, 16'sd1000);
      group(1, -16'sd20000);
      group(2, 16'sd0);
      group(2, 16'sd0);
      for (int g = 0; g < 48; g++) begin
         logic signed [15:0] v;
         v = 16'(g * 7919 - 30000);
         group(g % 3, v);
      end
      @(negedge clk);
      check("R2 R3 R4 R5 final pdm_out", pdm_out, mout);
      done = 1'b1;
   end

   initial begin
      for (int n = 0; n < 200000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired actual=running expected=done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule